// File: doc/BRIEF.md
# Soft-Start and Hiccup Fault Sequencer

This block sets the duty ceiling of a half-bridge PWM controller. It keeps a digital soft-start level in an up/down counter, which takes the place of a soft-start capacitor. It also runs a shutdown-and-retry cycle for five fault sources.

At power-up the level climbs one code at a time toward a clamp. The clamp stands for the largest duty cycle the PWM may use. The PWM compares its ramp against the level, so a low level means short pulses.

Faults are handled as follows:
- **Moderate overcurrent:** only acted on once a start has finished. The response is a gradual derating that is tied to the switching period.
- **Severe overcurrent:** acted on at any time. It shuts the drivers off at once and starts a slow drain.
- **Supply undervoltage, system undervoltage, over-temperature:** each shuts the drivers off at once and drains the level quickly.

After every shutdown the level has to reach a floor before the block retries. Where the fault needs to clear, it must also have cleared. The retry is always a fresh ramp from the floor.

The fault inputs arrive as synchronous flags from comparators outside the block. The period-start and low-phase indications come from the PWM.

Top module: `ss_hiccup_seq`

## Requirements
- R1: While `rst_ni` is low, `ss_level_o` is 0 and `force_off_o` is 1. After release, a ramp starts from 0.
- R2: During a start, the level rises by exactly 1 every FAST_DIV clocks until it equals LVL_MAX.
- R3: The level never exceeds LVL_MAX. Once there, it holds with `force_off_o` low while no fault is present.
- R4: `moc_i` has no effect while a start ramp is still in progress.
- R5: After a completed start, if `moc_i` is high in a cycle where `low_phase_i` is high, the level falls by 1 every FAST_DIV clocks. This stops at the edge that samples `period_start_i`, after which the level recharges to LVL_MAX. If `moc_i` is high while `low_phase_i` is low, it is ignored.
- R6: If derating takes the level below LVL_TRIP, `force_off_o` rises on the next clock with the level at LVL_TRIP-1. The level then falls by 1 every FAST_DIV*SLOW_RATIO clocks.
- R7: Any drain stops at LVL_FLOOR. `force_off_o` falls only with the level at or below LVL_FLOOR, and a new ramp then starts from there.
- R8: `soc_i` raises `force_off_o` in the same cycle, also during a ramp. It starts the slow drain.
- R9: `uv_vcc_i` or `uv_sys_i` raises `force_off_o` in the same cycle and starts the fast drain. The level stays at LVL_FLOOR with the drivers off until the undervoltage clears.
- R10: A pulse on `ot_set_i` latches an over-temperature condition. The condition forces the fast drain and holds the drivers off at the floor until a pulse on `ot_clr_i` arrives.
- R11: When faults arrive together, undervoltage and over-temperature win over severe overcurrent, and severe overcurrent wins over moderate overcurrent.
- R12: A fault that arrives while a drain is in progress does not change the drain rate and does not restart the drain.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| period_start_i | input | 1 | Pulse marking the start of a low-side cycle (new switching period) |
| low_phase_i | input | 1 | High during the oscillator cycle in which the low-side output may be on |
| moc_i | input | 1 | Moderate overcurrent flag |
| soc_i | input | 1 | Severe overcurrent flag |
| uv_vcc_i | input | 1 | Controller supply undervoltage flag |
| uv_sys_i | input | 1 | System input undervoltage flag |
| ot_set_i | input | 1 | Temperature rose past the upper threshold |
| ot_clr_i | input | 1 | Temperature fell below the lower threshold |
| ss_level_o | output | LVL_W | Soft-start level passed to the PWM |
| force_off_o | output | 1 | Holds both gate drivers low |

## Verification
The sharpest collisions are cases where two faults land on the same clock edge. In the main one, severe overcurrent, system undervoltage and moderate overcurrent are all raised together while the block runs at the clamp. The drain rate that follows is the verdict: the level must have dropped by exactly 10 codes twenty clocks later, which only the fast path gives.

A second collision is a moderate-overcurrent pulse whose derating window ends on a `period_start_i` edge that also carries a scheduled step. Its random length shows whether that last step is counted. A third is a pair of faults injected in the middle of a slow drain. That drain must keep its spacing of FAST_DIV*SLOW_RATIO clocks down to the floor.

// File: rtl/ss_hiccup_pkg.sv
package ss_hiccup_pkg;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,  // at floor, waiting for restart conditions
    ST_RAMP   = 3'd1,  // soft-start charge, moc not armed
    ST_RUN    = 3'd2,  // start complete, moc armed
    ST_DERATE = 3'd3,  // moc pull-down until next period start
    ST_SLOW   = 3'd4,  // hiccup drain at slow rate
    ST_FAST   = 3'd5   // shutdown drain at fast rate
  } ss_state_e;

endpackage

// File: rtl/ss_step_timer.sv
module ss_step_timer #(
  parameter int DIV = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clear_i,
  output logic tick_o
);

  localparam int CNT_W = (DIV > 1) ? $clog2(DIV) : 1;

  generate
    if (DIV > 1) begin : g_div
      localparam logic [CNT_W-1:0] LAST = CNT_W'(DIV - 1);
      logic [CNT_W-1:0] cnt_q;

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)             cnt_q <= '0;
        else if (clear_i)        cnt_q <= '0;
        else if (cnt_q == LAST)  cnt_q <= '0;
        else                     cnt_q <= cnt_q + 1'b1;
      end

      assign tick_o = (cnt_q == LAST);
    end else begin : g_every
      assign tick_o = 1'b1;
    end
  endgenerate

endmodule

// File: rtl/ss_level_ctr.sv
module ss_level_ctr #(
  parameter int LVL_W     = 8,
  parameter int LVL_MAX   = 200,
  parameter int LVL_FLOOR = 11
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             up_i,
  input  logic             dn_i,
  output logic [LVL_W-1:0] level_o
);

  localparam logic [LVL_W-1:0] MAX_L   = LVL_W'(LVL_MAX);
  localparam logic [LVL_W-1:0] FLOOR_L = LVL_W'(LVL_FLOOR);

  logic [LVL_W-1:0] level_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          level_q <= '0;
    else if (up_i && level_q < MAX_L)     level_q <= level_q + 1'b1;
    else if (dn_i && level_q > FLOOR_L)   level_q <= level_q - 1'b1;
  end

  assign level_o = level_q;

endmodule

// File: rtl/ss_seq_fsm.sv
module ss_seq_fsm
  import ss_hiccup_pkg::*;
#(
  parameter int LVL_W     = 8,
  parameter int LVL_MAX   = 200,
  parameter int LVL_TRIP  = 178,
  parameter int LVL_FLOOR = 11
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             period_start_i,
  input  logic             low_phase_i,
  input  logic             moc_i,
  input  logic             soc_i,
  input  logic             uv_i,
  input  logic             ot_set_i,
  input  logic             ot_clr_i,
  input  logic [LVL_W-1:0] level_i,
  input  logic             fast_tick_i,
  input  logic             slow_tick_i,
  output logic             up_o,
  output logic             dn_o,
  output logic             restep_o,
  output logic             off_o
);

  localparam logic [LVL_W-1:0] MAX_L   = LVL_W'(LVL_MAX);
  localparam logic [LVL_W-1:0] TRIP_L  = LVL_W'(LVL_TRIP);
  localparam logic [LVL_W-1:0] FLOOR_L = LVL_W'(LVL_FLOOR);

  ss_state_e state_q, state_d;
  logic      ot_hot_q;
  logic      shut;
  logic      moc_hit;
  logic      off_state;

  // over-temperature hysteresis latch, set wins
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       ot_hot_q <= 1'b0;
    else if (ot_set_i) ot_hot_q <= 1'b1;
    else if (ot_clr_i) ot_hot_q <= 1'b0;
  end

  assign shut    = uv_i | ot_set_i | ot_hot_q;
  assign moc_hit = moc_i & low_phase_i;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: begin
        if (!shut && !soc_i) state_d = ST_RAMP;
      end
      ST_RAMP: begin
        if (shut)                  state_d = ST_FAST;
        else if (soc_i)            state_d = ST_SLOW;
        else if (level_i >= MAX_L) state_d = ST_RUN;
      end
      ST_RUN: begin
        if (shut)         state_d = ST_FAST;
        else if (soc_i)   state_d = ST_SLOW;
        else if (moc_hit) state_d = ST_DERATE;
      end
      ST_DERATE: begin
        if (shut)                              state_d = ST_FAST;
        else if (soc_i)                        state_d = ST_SLOW;
        else if (level_i < TRIP_L)             state_d = ST_SLOW;
        else if (period_start_i && !moc_hit)   state_d = ST_RUN;
      end
      ST_SLOW, ST_FAST: begin
        // new faults are absorbed until the floor is reached
        if (level_i <= FLOOR_L) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  assign off_state = (state_q == ST_IDLE) || (state_q == ST_SLOW) || (state_q == ST_FAST);

  assign up_o = ((state_q == ST_RAMP) || (state_q == ST_RUN)) && fast_tick_i && !soc_i && !shut;
  assign dn_o = (((state_q == ST_DERATE) || (state_q == ST_FAST)) && fast_tick_i) ||
                ((state_q == ST_SLOW) && slow_tick_i);
  assign restep_o = (state_d != state_q);
  assign off_o    = off_state | soc_i | shut;

endmodule

// File: rtl/ss_hiccup_seq.sv
module ss_hiccup_seq #(
  parameter int LVL_W      = 8,
  parameter int LVL_MAX    = 200,
  parameter int LVL_TRIP   = 178,
  parameter int LVL_FLOOR  = 11,
  parameter int FAST_DIV   = 2,
  parameter int SLOW_RATIO = 50
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             period_start_i,
  input  logic             low_phase_i,
  input  logic             moc_i,
  input  logic             soc_i,
  input  logic             uv_vcc_i,
  input  logic             uv_sys_i,
  input  logic             ot_set_i,
  input  logic             ot_clr_i,
  output logic [LVL_W-1:0] ss_level_o,
  output logic             force_off_o
);

  localparam int SLOW_DIV = FAST_DIV * SLOW_RATIO;

  logic fast_tick, slow_tick;
  logic up, dn, restep;
  logic [LVL_W-1:0] level;

  ss_step_timer #(.DIV(FAST_DIV)) u_fast_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (restep),
    .tick_o  (fast_tick)
  );

  ss_step_timer #(.DIV(SLOW_DIV)) u_slow_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (restep),
    .tick_o  (slow_tick)
  );

  ss_level_ctr #(
    .LVL_W     (LVL_W),
    .LVL_MAX   (LVL_MAX),
    .LVL_FLOOR (LVL_FLOOR)
  ) u_level (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .up_i    (up),
    .dn_i    (dn),
    .level_o (level)
  );

  ss_seq_fsm #(
    .LVL_W     (LVL_W),
    .LVL_MAX   (LVL_MAX),
    .LVL_TRIP  (LVL_TRIP),
    .LVL_FLOOR (LVL_FLOOR)
  ) u_fsm (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .period_start_i (period_start_i),
    .low_phase_i    (low_phase_i),
    .moc_i          (moc_i),
    .soc_i          (soc_i),
    .uv_i           (uv_vcc_i | uv_sys_i),
    .ot_set_i       (ot_set_i),
    .ot_clr_i       (ot_clr_i),
    .level_i        (level),
    .fast_tick_i    (fast_tick),
    .slow_tick_i    (slow_tick),
    .up_o           (up),
    .dn_o           (dn),
    .restep_o       (restep),
    .off_o          (force_off_o)
  );

  assign ss_level_o = level;

endmodule

// File: rtl/ss_hiccup_seq_chk.sv
module ss_hiccup_seq_chk #(
  parameter int LVL_W     = 8,
  parameter int LVL_MAX   = 200,
  parameter int LVL_FLOOR = 11
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             soc_i,
  input logic             uv_vcc_i,
  input logic             uv_sys_i,
  input logic             ot_set_i,
  input logic [LVL_W-1:0] ss_level_o,
  input logic             force_off_o
);

  localparam logic [LVL_W-1:0] MAX_L   = LVL_W'(LVL_MAX);
  localparam logic [LVL_W-1:0] FLOOR_L = LVL_W'(LVL_FLOOR);

  assert_unit_step_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ss_level_o == $past(ss_level_o)) ||
    (ss_level_o == $past(ss_level_o) + 1'b1) ||
    (ss_level_o == $past(ss_level_o) - 1'b1));

  assert_clamp_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ss_level_o <= MAX_L);

  assert_restart_floor_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(force_off_o) |-> ss_level_o <= FLOOR_L);

  assert_soc_holds_off_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soc_i |=> force_off_o);

  assert_uv_holds_off_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (uv_vcc_i || uv_sys_i) |=> force_off_o);

  assert_off_no_rise_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    force_off_o |=> ss_level_o <= $past(ss_level_o));

  assert_ot_holds_off_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ot_set_i |=> force_off_o);

endmodule

bind ss_hiccup_seq ss_hiccup_seq_chk #(
  .LVL_W     (LVL_W),
  .LVL_MAX   (LVL_MAX),
  .LVL_FLOOR (LVL_FLOOR)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .soc_i       (soc_i),
  .uv_vcc_i    (uv_vcc_i),
  .uv_sys_i    (uv_sys_i),
  .ot_set_i    (ot_set_i),
  .ss_level_o  (ss_level_o),
  .force_off_o (force_off_o)
);

// File: tb/ss_hiccup_seq_bench.sv
module ss_hiccup_seq_bench;

  localparam int LVL_W      = 8;
  localparam int LVL_MAX    = 200;
  localparam int LVL_TRIP   = 178;
  localparam int LVL_FLOOR  = 11;
  localparam int FAST_DIV   = 2;
  localparam int SLOW_RATIO = 50;
  localparam int SLOW_DIV   = FAST_DIV * SLOW_RATIO;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic period_start = 1'b0, low_phase = 1'b0, moc = 1'b0, soc = 1'b0;
  logic uv_vcc = 1'b0, uv_sys = 1'b0, ot_set = 1'b0, ot_clr = 1'b0;
  logic [LVL_W-1:0] level;
  logic force_off;

  int n_vec = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  ss_hiccup_seq #(
    .LVL_W(LVL_W), .LVL_MAX(LVL_MAX), .LVL_TRIP(LVL_TRIP),
    .LVL_FLOOR(LVL_FLOOR), .FAST_DIV(FAST_DIV), .SLOW_RATIO(SLOW_RATIO)
  ) u_ss_hiccup_seq (
    .clk_i(clk), .rst_ni(rst_n), .period_start_i(period_start),
    .low_phase_i(low_phase), .moc_i(moc), .soc_i(soc),
    .uv_vcc_i(uv_vcc), .uv_sys_i(uv_sys), .ot_set_i(ot_set), .ot_clr_i(ot_clr),
    .ss_level_o(level), .force_off_o(force_off)
  );

  function automatic int exp_derate_min(input int gap);
    return LVL_MAX - gap / FAST_DIV;
  endfunction

  function automatic int exp_after_drain(input int start, input int edges, input int div);
    return start - edges / div;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // follow level until target, checking step size, spacing and force_off
  task automatic track(input int dir, input int intv, input int target,
                       input logic exp_off, input int limit, input string req);
    int last_lvl = int'(level);
    int last_t = 0;
    int bad_step = 0;
    int bad_off = 0;
    bit seen = 1'b0;
    for (int t = 1; t <= limit; t++) begin
      @(negedge clk);
      if (force_off !== exp_off) bad_off++;
      if (int'(level) != last_lvl) begin
        if (int'(level) - last_lvl != dir) bad_step++;
        else if (seen && (t - last_t) != intv) bad_step++;
        seen = 1'b1;
        last_t = t;
        last_lvl = int'(level);
      end
      if (last_lvl == target) break;
    end
    chk(last_lvl == target, req, last_lvl, target);
    chk(bad_step == 0, req, bad_step, 0);
    chk(bad_off == 0, req, bad_off, 0);
  endtask

  task automatic wait_restart(input string req);
    bit got = 1'b0;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      if (!force_off) begin got = 1'b1; break; end
    end
    chk(got, req, int'(force_off), 0);
    chk(int'(level) == LVL_FLOOR, req, int'(level), LVL_FLOOR);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_vec++;
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    int g;
    int mn;
    int lvl_at_off;
    bit hit;
    void'($urandom(32'd20240611));

    // R1: reset state
    repeat (3) @(negedge clk);
    chk(level == '0, "R1", int'(level), 0);
    chk(force_off == 1'b1, "R1", int'(force_off), 1);
    rst_n = 1'b1;

    // R1 R2: ramp from zero to clamp
    track(1, FAST_DIV, LVL_MAX, 1'b0, 2000, "R2");

    // R3: hold at clamp
    repeat (50) @(negedge clk);
    chk(int'(level) == LVL_MAX && !force_off, "R3", int'(level), LVL_MAX);

    // R5: moc outside low phase ignored
    moc = 1'b1; low_phase = 1'b0;
    repeat (20) @(negedge clk);
    chk(int'(level) == LVL_MAX, "R5", int'(level), LVL_MAX);
    moc = 1'b0;

    // R5: random derate windows closed by period start
    for (int i = 0; i < 6; i++) begin
      g = 4 + int'($urandom_range(26));
      moc = 1'b1; low_phase = 1'b1;
      @(negedge clk);
      moc = 1'b0;
      mn = int'(level);
      for (int k = 0; k < g - 1; k++) begin
        @(negedge clk);
        if (int'(level) < mn) mn = int'(level);
      end
      period_start = 1'b1;
      @(negedge clk);
      period_start = 1'b0;
      if (int'(level) < mn) mn = int'(level);
      repeat (4) begin
        @(negedge clk);
        if (int'(level) < mn) mn = int'(level);
      end
      chk(mn == exp_derate_min(g), "R5", mn, exp_derate_min(g));
      track(1, FAST_DIV, LVL_MAX, 1'b0, 200, "R5");
      low_phase = 1'b0;
      repeat (3) @(negedge clk);
    end

    // R6: sustained moc derates to trip, hiccup
    moc = 1'b1; low_phase = 1'b1;
    hit = 1'b0;
    lvl_at_off = -1;
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      if (force_off) begin hit = 1'b1; lvl_at_off = int'(level); break; end
    end
    moc = 1'b0; low_phase = 1'b0;
    chk(hit, "R6", int'(hit), 1);
    chk(lvl_at_off == LVL_TRIP - 1, "R6", lvl_at_off, LVL_TRIP - 1);
    track(-1, SLOW_DIV, LVL_FLOOR, 1'b1, 20000, "R6");

    // R7: restart from floor
    wait_restart("R7");
    track(1, FAST_DIV, LVL_MAX, 1'b0, 1000, "R7");

    // R9: supply undervoltage, immediate off, fast drain, wait at floor
    @(negedge clk);
    uv_vcc = 1'b1;
    #1 chk(force_off == 1'b1, "R9", int'(force_off), 1);
    track(-1, FAST_DIV, LVL_FLOOR, 1'b1, 1000, "R9");
    repeat (50) @(negedge clk);
    chk(int'(level) == LVL_FLOOR && force_off, "R9", int'(level), LVL_FLOOR);
    uv_vcc = 1'b0;
    moc = 1'b1; low_phase = 1'b1;
    wait_restart("R9");
    // R4: moc held through whole ramp has no effect
    track(1, FAST_DIV, LVL_MAX, 1'b0, 1000, "R4");
    moc = 1'b0; low_phase = 1'b0;
    repeat (10) @(negedge clk);
    chk(int'(level) == LVL_MAX && !force_off, "R4", int'(level), LVL_MAX);

    // R10: over-temperature latch
    ot_set = 1'b1;
    #1 chk(force_off == 1'b1, "R10", int'(force_off), 1);
    @(negedge clk);
    ot_set = 1'b0;
    track(-1, FAST_DIV, LVL_FLOOR, 1'b1, 1000, "R10");
    repeat (200) @(negedge clk);
    chk(int'(level) == LVL_FLOOR && force_off, "R10", int'(force_off), 1);
    ot_clr = 1'b1;
    @(negedge clk);
    ot_clr = 1'b0;
    wait_restart("R10");
    track(1, FAST_DIV, LVL_MAX, 1'b0, 1000, "R10");

    // R11: soc, system uv and moc in the same cycle -> fast drain wins
    @(negedge clk);
    soc = 1'b1; uv_sys = 1'b1; moc = 1'b1; low_phase = 1'b1;
    #1 chk(force_off == 1'b1, "R11", int'(force_off), 1);
    @(negedge clk);
    soc = 1'b0; moc = 1'b0; low_phase = 1'b0;
    repeat (20) @(negedge clk);
    chk(int'(level) == exp_after_drain(LVL_MAX, 20, FAST_DIV), "R11",
        int'(level), exp_after_drain(LVL_MAX, 20, FAST_DIV));
    track(-1, FAST_DIV, LVL_FLOOR, 1'b1, 1000, "R11");
    uv_sys = 1'b0;
    wait_restart("R11");

    // R8: soc during ramp
    hit = 1'b0;
    for (int i = 0; i < 200; i++) begin
      if (int'(level) == 40) begin hit = 1'b1; break; end
      @(negedge clk);
    end
    chk(hit, "R8", int'(level), 40);
    soc = 1'b1;
    #1 chk(force_off == 1'b1, "R8", int'(force_off), 1);
    @(negedge clk);
    soc = 1'b0;
    track(-1, SLOW_DIV, 30, 1'b1, 2000, "R8");

    // R12: faults during slow drain are absorbed
    soc = 1'b1;
    @(negedge clk);
    soc = 1'b0; uv_vcc = 1'b1;
    @(negedge clk);
    uv_vcc = 1'b0;
    track(-1, SLOW_DIV, LVL_FLOOR, 1'b1, 3000, "R12");
    wait_restart("R12");
    track(1, FAST_DIV, LVL_MAX, 1'b0, 1000, "R12");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule